// File: doc/BRIEF.md
# One-Shot Edge-Aligned Pulse Timer

This block produces exactly one edge-aligned pulse each time it is armed. A one-cycle arm strobe while the block is idle starts an internal up-counter from zero and drives the pulse output active. The pulse returns inactive when the counter reaches the programmed duty value. When the counter reaches the programmed period value, the block stops itself. It clears the counter, forces the pulse inactive, drops its busy status and raises a single-cycle completion interrupt. It then waits idle until it is armed again.

Software or a sequencer uses it to fire one timed pulse, such as a single gate pulse or a measurement strobe, without having to stop a free-running generator. Duty and period are live inputs. A new value takes part in the comparison on the next clock edge, even in the middle of a pulse.

Top module: `spwm_single_shot`

## Requirements
- R1: While reset is high and in the first cycle after reset, busy, pulse_out and irq are all low and the internal counter is zero.
- R2: An arm strobe sampled while idle makes busy high from the next cycle. In that same first busy cycle pulse_out is high whenever duty is nonzero.
- R3: For 1 <= duty <= period, pulse_out is high for exactly duty consecutive cycles, starting with the first busy cycle.
- R4: With duty equal to zero, pulse_out stays low for the whole shot.
- R5: With duty greater than period, pulse_out stays high for the whole busy window and drops together with busy.
- R6: The busy window lasts period+1 cycles, one for each counter value from 0 through period. Busy then clears itself and pulse_out is forced low.
- R7: irq is high for exactly one cycle, the cycle right after the last busy cycle, and is never high at any other time.
- R8: An arm strobe that arrives while busy is ignored. The shot in progress keeps its original length and pulse shape.
- R9: Duty and period are compared live. Moving duty to a value above the current count ends the pulse at the new value. Moving it to a value at or below the count already passed leaves the pulse high until the shot ends. Moving period to a value above the count ends the shot at the new value.
- R10: After a shot, the block stays idle with all outputs low until the next arm, and a new arm repeats a complete shot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle request to start a shot; honoured only when idle |
| duty | input | CNT_W | Count at which the pulse returns inactive |
| period | input | CNT_W | Final count of the shot |
| pulse_out | output | 1 | Pulse output, high = active |
| busy | output | 1 | High while a shot is in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the edges of the pulse window: duty of zero, duty equal to period, duty one above period, and a period of zero. An off-by-one in the duty match would stretch or shorten the pulse by one cycle, and a bad zero-duty case would leave a one-cycle glitch at the start of the shot. It arms the block again while a shot is running. A design that restarted on this would show a longer busy window. It also rewrites duty and period in the middle of a shot, both above and below the running count, which catches a design that latches its compare values at arm time or matches on a count that has already gone by.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    // Controller state of a single shot
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } shot_state_t;

    // Match results handed from the comparator to the controller
    typedef struct packed {
        logic duty_hit;    // next count equals duty
        logic period_hit;  // current count equals period
    } cmp_hits_t;

    // Default counter width
    localparam int unsigned CNT_W_DEFAULT = 16;

endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
    parameter int unsigned CNT_W = spwm_pkg::CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             wrap,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic clear_now;
    logic step_now;

    assign clear_now = rst || start || wrap;
    assign step_now  = run && !wrap;

    always_ff @(posedge clk) begin
        if (clear_now) begin
            cnt <= CNT_ZERO;
        end else if (step_now) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // R1
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (cnt == CNT_ZERO));

    // R6
    wrap_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
        (run && wrap) |=> (cnt == CNT_ZERO));

endmodule

// File: rtl/spwm_compare.sv
module spwm_compare #(
    parameter int unsigned CNT_W = spwm_pkg::CNT_W_DEFAULT
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  duty,
    input  logic [CNT_W-1:0]  period,
    output spwm_pkg::cmp_hits_t hits
);

    // One extra bit keeps the incremented count from aliasing duty zero
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] next_cnt;
    logic [EXT_W-1:0] duty_ext;

    assign next_cnt = {1'b0, cnt} + EXT_W'(1);
    assign duty_ext = {1'b0, duty};

    always_comb begin
        hits.duty_hit   = (next_cnt == duty_ext);
        hits.period_hit = (cnt == period);
    end

endmodule

// File: rtl/spwm_ctrl.sv
module spwm_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                duty_zero,
    input  spwm_pkg::cmp_hits_t hits,
    output logic                run,
    output logic                act,
    output logic                irq,
    output logic                start,
    output logic                wrap
);
    import spwm_pkg::*;

    shot_state_t state;

    assign run   = (state == ST_RUN);
    assign start = (state == ST_IDLE) && arm;
    assign wrap  = (state == ST_RUN) && hits.period_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            act   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= wrap;
            unique case (state)
                ST_IDLE: begin
                    if (arm) begin
                        state <= ST_RUN;
                        act   <= !duty_zero;
                    end
                end
                ST_RUN: begin
                    if (hits.period_hit) begin
                        state <= ST_IDLE;
                        act   <= 1'b0;
                    end else if (hits.duty_hit) begin
                        act <= 1'b0;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    act   <= 1'b0;
                end
            endcase
        end
    end

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R6
    busy_fall_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> irq);

    // R5
    pulse_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        act |-> run);

    // R2
    arm_starts_shot_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && arm) |=> (run && (act == !$past(duty_zero))));

    // R8
    arm_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (run && arm && !hits.period_hit) |=> run);

endmodule

// File: rtl/spwm_single_shot.sv
module spwm_single_shot #(
    parameter int unsigned CNT_W = spwm_pkg::CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] period,
    output logic             pulse_out,
    output logic             busy,
    output logic             irq
);
    import spwm_pkg::*;

    localparam logic [CNT_W-1:0] DUTY_NONE = '0;

    logic [CNT_W-1:0] cnt;
    cmp_hits_t        hits;
    logic             run;
    logic             act;
    logic             start;
    logic             wrap;
    logic             duty_zero;

    assign duty_zero = (duty == DUTY_NONE);

    spwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (run),
        .wrap  (wrap),
        .cnt   (cnt)
    );

    spwm_compare #(.CNT_W(CNT_W)) u_compare (
        .cnt    (cnt),
        .duty   (duty),
        .period (period),
        .hits   (hits)
    );

    spwm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .duty_zero (duty_zero),
        .hits      (hits),
        .run       (run),
        .act       (act),
        .irq       (irq),
        .start     (start),
        .wrap      (wrap)
    );

    assign pulse_out = act;
    assign busy      = run;

    // R10
    idle_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (!pulse_out && !irq));

endmodule

// File: tb/sim_spwm_single_shot.sv
module sim_spwm_single_shot;

    localparam int W = 16;
    localparam int NEVER = 1 << 20;

    logic         clk = 1'b0;
    logic         rst;
    logic         arm;
    logic [W-1:0] duty;
    logic [W-1:0] period;
    logic         pulse_out;
    logic         busy;
    logic         irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    spwm_single_shot #(.CNT_W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .duty      (duty),
        .period    (period),
        .pulse_out (pulse_out),
        .busy      (busy),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic eb, input logic ep, input logic ei);
        n_vec = n_vec + 1;
        if (busy !== eb || pulse_out !== ep || irq !== ei) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual busy=%b pulse=%b irq=%b expected busy=%b pulse=%b irq=%b",
                     req, busy, pulse_out, irq, eb, ep, ei);
        end
    endtask

    // Index at which the pulse drops, given an optional mid-shot duty rewrite
    function automatic int pulse_end(input int d, input int chgk, input int nd);
        if (chgk < 0 || d <= chgk) return d;
        if (nd >= chgk + 1) return nd;
        return NEVER;
    endfunction

    // One shot: arm, then check every cycle through one idle cycle after irq
    task automatic run_shot(input string tag, input int d, input int p,
                            input int chgk, input int nd, input int np,
                            input bit mid_arm);
        int last;
        int pend;
        last = (chgk >= 0) ? np : p;
        pend = pulse_end(d, chgk, nd);
        duty   = W'(d);
        period = W'(p);
        arm    = 1'b1;
        step();
        arm = 1'b0;
        for (int k = 0; k <= last + 2; k++) begin
            chk(tag, k <= last, (k <= last) && (k < pend), k == last + 1);
            if (k == chgk) begin
                duty   = W'(nd);
                period = W'(np);
            end
            if (mid_arm && k == 1) arm = 1'b1;
            if (mid_arm && k == 2) arm = 1'b0;
            step();
        end
    endtask

    initial begin
        int unsigned seed;
        rst    = 1'b1;
        arm    = 1'b0;
        duty   = '0;
        period = '0;
        seed = $urandom(32'd20240611);
        repeat (3) step();
        chk("R1 in reset", 1'b0, 1'b0, 1'b0);
        // arm during reset must not start anything
        arm = 1'b1;
        step();
        arm = 1'b0;
        rst = 1'b0;
        step();
        chk("R1 after reset", 1'b0, 1'b0, 1'b0);

        run_shot("R3 basic",            5, 12, -1, 0, 0, 1'b0);
        run_shot("R4 zero duty",        0, 10, -1, 0, 0, 1'b0);
        run_shot("R3 duty equals period", 12, 12, -1, 0, 0, 1'b0);
        run_shot("R5 duty period+1",    13, 12, -1, 0, 0, 1'b0);
        run_shot("R5 large duty",       40, 12, -1, 0, 0, 1'b0);
        run_shot("R6 zero period",      1,  0, -1, 0, 0, 1'b0);
        run_shot("R6 zero period zero duty", 0, 0, -1, 0, 0, 1'b0);
        run_shot("R2 duty one",         1,  6, -1, 0, 0, 1'b0);
        run_shot("R8 arm while busy",   4,  9, -1, 0, 0, 1'b1);
        run_shot("R9 duty raised",      10, 20, 3, 6, 20, 1'b0);
        run_shot("R9 duty below count", 10, 20, 5, 2, 20, 1'b0);
        run_shot("R9 period lowered",   3,  20, 5, 3, 8, 1'b0);
        run_shot("R9 period raised",    30, 10, 4, 30, 15, 1'b0);

        // R10 idle gap then a repeat shot
        repeat (4) begin
            step();
            chk("R10 idle", 1'b0, 1'b0, 1'b0);
        end
        run_shot("R10 repeat", 5, 12, -1, 0, 0, 1'b0);

        for (int i = 0; i < 40; i++) begin
            int p;
            int d;
            int gap;
            p   = int'($urandom_range(0, 40));
            d   = int'($urandom_range(0, p + 3));
            gap = int'($urandom_range(0, 3));
            run_shot("R3/R4/R5/R6/R7 random", d, p, -1, 0, 0, (p >= 2) && (i % 5 == 0));
            for (int g = 0; g < gap; g++) begin
                step();
                chk("R10 random idle", 1'b0, 1'b0, 1'b0);
            end
        end

        if (seed == 32'hFFFF_FFFF) $display("seed %0d", seed);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule